// File: doc/BRIEF.md
# Cartridge Bank Address Translator

This block sits between a console's CPU and video buses and the memories on a game cartridge. It turns 16-bit CPU addresses and 14-bit video pattern addresses into physical program-ROM, character-memory and work-RAM addresses. The bank and mode fields come from a serial register interface elsewhere on the cartridge and arrive here as plain inputs. Program memory is switched either as one 32 KB window or as two 16 KB windows, one of them pinned. Character memory is switched as one 8 KB window or as two independent 4 KB halves.

Size parameters give the program, character, character-RAM and work-RAM sizes, and every bank number is masked to the fitted size. A variant parameter reuses bits of the first character-bank field. In one variant, bit 4 supplies the program bank's top bit so that 512 KB of program ROM can be reached. In two others, one or two of its bits select the work-RAM page. All outputs are registered, so each translation appears one clock after its inputs.

Top module: `bank_xlat`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge.
- R2: With `prg_mode`=0 (32 KB switching), CPU address bit 14 = 0 selects bank `prg_bank` and bit 14 = 1 selects bank `prg_bank`+1, where the sum is 5 bits wide before masking.
- R3: With `prg_mode`=1 and `prg_slot`=0, the window at bit 14 = 0 is bank 0 and the window at bit 14 = 1 is bank `prg_bank`.
- R4: With `prg_mode`=1 and `prg_slot`=1, the window at bit 14 = 0 is bank `prg_bank` and the window at bit 14 = 1 is bank 15.
- R5: `prg_addr` = ((bank AND (PRG_KB/16 - 1)) × 16384) + `cpu_addr[13:0]`, and `rom_sel` = `cpu_addr[15]`, both one clock after the inputs.
- R6: With `chr_mode`=0, video bit 12 = 0 uses `chr_bank0` and bit 12 = 1 uses `chr_bank0`+1, where the sum is 6 bits wide before masking.
- R7: With `chr_mode`=1, video bit 12 = 0 uses `chr_bank0` and bit 12 = 1 uses `chr_bank1`.
- R8: For character ROM (CHR_KB > 0), `chr_addr` = ((bank AND (CHR_KB/4 - 1)) × 4096) + `ppu_addr[11:0]`. `chr_sel` = NOT `ppu_addr[13]`, one clock after the inputs.
- R9: For character RAM (CHR_KB = 0), `chr_addr` = `ppu_addr[12:0]` AND (VRAM_KB×1024 - 1). `chr_we` = `ppu_wr` AND NOT `ppu_addr[13]`. With character ROM, `chr_we` is always 0.
- R10: In the large-program variant (VARIANT = VAR_BIGPRG), `chr_bank0[4]` is ORed into program bank bit 4 in every mode before masking.
- R11: In the two-page variant (VAR_RAM2), `chr_bank0[3]` is the work-RAM page.
- R12: In the four-page variant (VAR_RAM4), `chr_bank0[3:2]` is the work-RAM page.
- R13: `wram_addr` = (page × 8192 + `cpu_addr[12:0]`) AND (WRAM_KB×1024 - 1), with page 0 outside R11/R12. `wram_sel` = (`cpu_addr[15:13]` = 3'b011) AND NOT `wram_dis`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU bus address |
| ppu_addr | input | 14 | Video bus address |
| ppu_wr | input | 1 | Video bus write strobe |
| prg_mode | input | 1 | 0: 32 KB program switching, 1: 16 KB with one fixed window |
| prg_slot | input | 1 | In 16 KB mode, which window is fixed (0: lower at bank 0, 1: upper at bank 15) |
| chr_mode | input | 1 | 0: 8 KB character switching, 1: two 4 KB halves |
| prg_bank | input | 4 | Program bank field |
| chr_bank0 | input | 5 | First character bank field (also variant bits) |
| chr_bank1 | input | 5 | Second character bank field |
| wram_dis | input | 1 | Work-RAM disable |
| prg_addr | output | PRG_AW | Physical program-ROM address |
| rom_sel | output | 1 | Program-ROM access |
| wram_addr | output | WRAM_AW | Physical work-RAM address |
| wram_sel | output | 1 | Work-RAM access enabled |
| chr_addr | output | CHR_AW | Physical character-memory address |
| chr_sel | output | 1 | Character-memory access |
| chr_we | output | 1 | Character-RAM write enable |

## Verification
Four instances run side by side: a plain one with character ROM, a large-program one, a two-page one and a four-page one with character RAM or ROM. Each gets seeded random mode, bank and address patterns. The random sweep mixes both program modes and slots with both address-bit-14 values, which separates the bank+1 rule from the fixed-bank rules. It also mixes both character modes, which separates the paired 8 KB bank from the independent halves. Directed corners push the 5-bit bank+1 and 6-bit character+1 sums past the mask, where a wrong width or mask order gives a different address. They also set bit 4 of the first character field under a fixed window, drive video writes to a ROM board, and disable work RAM over its own range.

// File: rtl/bank_xlat_pkg.sv
package bank_xlat_pkg;

    typedef enum logic [1:0] {
        VAR_PLAIN  = 2'd0,
        VAR_BIGPRG = 2'd1,
        VAR_RAM2   = 2'd2,
        VAR_RAM4   = 2'd3
    } xlat_variant_e;

    typedef struct packed {
        logic       prg_mode;
        logic       prg_slot;
        logic       chr_mode;
        logic [3:0] prg_bank;
        logic [4:0] chr0;
        logic [4:0] chr1;
        logic       wram_dis;
    } xlat_ctrl_t;

    localparam logic [4:0] PRG_LAST_BANK = 5'd15;

    function automatic logic [4:0] pick_prg_bank(input xlat_ctrl_t c, input logic a14);
        logic [4:0] b;
        b = {1'b0, c.prg_bank};
        if (!c.prg_mode)
            return a14 ? b + 5'd1 : b;
        else if (!c.prg_slot)
            return a14 ? b : 5'd0;
        else
            return a14 ? PRG_LAST_BANK : b;
    endfunction

    function automatic logic [5:0] pick_chr_bank(input xlat_ctrl_t c, input logic a12);
        if (!c.chr_mode)
            return a12 ? {1'b0, c.chr0} + 6'd1 : {1'b0, c.chr0};
        else
            return a12 ? {1'b0, c.chr1} : {1'b0, c.chr0};
    endfunction

endpackage

// File: rtl/xlat_prg_map.sv
module xlat_prg_map
    import bank_xlat_pkg::*;
#(
    parameter xlat_variant_e VARIANT = VAR_PLAIN,
    parameter int PRG_KB = 256,
    parameter int PRG_AW = 18
) (
    input  xlat_ctrl_t        ctrl,
    input  logic [14:0]       cpu_lo,
    output logic [PRG_AW-1:0] rom_addr
);
    localparam logic [4:0] PMASK = 5'(PRG_KB / 16 - 1);

    logic [4:0] raw_bank;
    logic [4:0] full_bank;
    logic [4:0] bank_m;

    always_comb raw_bank = pick_prg_bank(ctrl, cpu_lo[14]);

    generate
        if (VARIANT == VAR_BIGPRG) begin : g_big
            always_comb full_bank = raw_bank | {ctrl.chr0[4], 4'd0};
        end else begin : g_std
            always_comb full_bank = raw_bank;
        end
    endgenerate

    always_comb begin
        bank_m   = full_bank & PMASK;
        rom_addr = PRG_AW'({bank_m, cpu_lo[13:0]});
    end

    logic unused_ctrl;
    assign unused_ctrl = ^ctrl;
endmodule

// File: rtl/xlat_chr_map.sv
module xlat_chr_map
    import bank_xlat_pkg::*;
#(
    parameter int CHR_KB  = 128,
    parameter int VRAM_KB = 8,
    parameter int CHR_AW  = 17
) (
    input  xlat_ctrl_t        ctrl,
    input  logic [12:0]       ppu_lo,
    output logic [CHR_AW-1:0] mem_addr
);
    generate
        if (CHR_KB == 0) begin : g_ram
            localparam logic [CHR_AW-1:0] VMASK = CHR_AW'(VRAM_KB * 1024 - 1);
            always_comb mem_addr = CHR_AW'(ppu_lo) & VMASK;
        end else begin : g_rom
            localparam logic [5:0] CMASK = 6'(CHR_KB / 4 - 1);
            logic [5:0] bank_m;
            always_comb begin
                bank_m   = pick_chr_bank(ctrl, ppu_lo[12]) & CMASK;
                mem_addr = CHR_AW'({bank_m, ppu_lo[11:0]});
            end
        end
    endgenerate

    logic unused_ctrl;
    assign unused_ctrl = ^ctrl;
endmodule

// File: rtl/xlat_wram_map.sv
module xlat_wram_map
    import bank_xlat_pkg::*;
#(
    parameter xlat_variant_e VARIANT = VAR_PLAIN,
    parameter int WRAM_AW = 13
) (
    input  xlat_ctrl_t         ctrl,
    input  logic [12:0]        cpu_lo,
    output logic [WRAM_AW-1:0] ram_addr
);
    logic [1:0] page;

    generate
        if (VARIANT == VAR_RAM2) begin : g_two
            always_comb page = {1'b0, ctrl.chr0[3]};
        end else if (VARIANT == VAR_RAM4) begin : g_four
            always_comb page = ctrl.chr0[3:2];
        end else begin : g_one
            always_comb page = 2'd0;
        end
    endgenerate

    always_comb ram_addr = WRAM_AW'({page, cpu_lo});

    logic unused_ctrl;
    assign unused_ctrl = ^ctrl;
endmodule

// File: rtl/bank_xlat.sv
module bank_xlat
    import bank_xlat_pkg::*;
#(
    parameter xlat_variant_e VARIANT = VAR_PLAIN,
    parameter int PRG_KB  = 256,
    parameter int CHR_KB  = 128,
    parameter int VRAM_KB = 8,
    parameter int WRAM_KB = 8,
    localparam int PRG_AW  = $clog2(PRG_KB * 1024),
    localparam int CHR_AW  = (CHR_KB == 0) ? $clog2(VRAM_KB * 1024) : $clog2(CHR_KB * 1024),
    localparam int WRAM_AW = $clog2(WRAM_KB * 1024)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [15:0]        cpu_addr,
    input  logic [13:0]        ppu_addr,
    input  logic               ppu_wr,
    input  logic               prg_mode,
    input  logic               prg_slot,
    input  logic               chr_mode,
    input  logic [3:0]         prg_bank,
    input  logic [4:0]         chr_bank0,
    input  logic [4:0]         chr_bank1,
    input  logic               wram_dis,
    output logic [PRG_AW-1:0]  prg_addr,
    output logic               rom_sel,
    output logic [WRAM_AW-1:0] wram_addr,
    output logic               wram_sel,
    output logic [CHR_AW-1:0]  chr_addr,
    output logic               chr_sel,
    output logic               chr_we
);
    localparam bit CHR_IS_RAM = (CHR_KB == 0);

    xlat_ctrl_t ctrl;
    always_comb begin
        ctrl.prg_mode = prg_mode;
        ctrl.prg_slot = prg_slot;
        ctrl.chr_mode = chr_mode;
        ctrl.prg_bank = prg_bank;
        ctrl.chr0     = chr_bank0;
        ctrl.chr1     = chr_bank1;
        ctrl.wram_dis = wram_dis;
    end

    logic [PRG_AW-1:0]  prg_nx;
    logic [CHR_AW-1:0]  chr_nx;
    logic [WRAM_AW-1:0] wram_nx;

    xlat_prg_map #(.VARIANT(VARIANT), .PRG_KB(PRG_KB), .PRG_AW(PRG_AW)) prg_map_i (
        .ctrl(ctrl), .cpu_lo(cpu_addr[14:0]), .rom_addr(prg_nx));

    xlat_chr_map #(.CHR_KB(CHR_KB), .VRAM_KB(VRAM_KB), .CHR_AW(CHR_AW)) chr_map_i (
        .ctrl(ctrl), .ppu_lo(ppu_addr[12:0]), .mem_addr(chr_nx));

    xlat_wram_map #(.VARIANT(VARIANT), .WRAM_AW(WRAM_AW)) wram_map_i (
        .ctrl(ctrl), .cpu_lo(cpu_addr[12:0]), .ram_addr(wram_nx));

    logic in_wram_win;
    always_comb in_wram_win = (cpu_addr[15:13] == 3'b011);

    always_ff @(posedge clk) begin
        if (rst) begin
            prg_addr  <= '0;
            rom_sel   <= 1'b0;
            wram_addr <= '0;
            wram_sel  <= 1'b0;
            chr_addr  <= '0;
            chr_sel   <= 1'b0;
            chr_we    <= 1'b0;
        end else begin
            prg_addr  <= prg_nx;
            rom_sel   <= cpu_addr[15];
            wram_addr <= wram_nx;
            wram_sel  <= in_wram_win && !wram_dis;
            chr_addr  <= chr_nx;
            chr_sel   <= !ppu_addr[13];
            chr_we    <= CHR_IS_RAM && ppu_wr && !ppu_addr[13];
        end
    end

    // R1: outputs cleared after a reset edge
    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!rom_sel && !wram_sel && !chr_sel && !chr_we && prg_addr == '0));

    // R5: in-bank offset passes through one clock later
    a_r5_prg_offset: assert property (@(posedge clk) disable iff (rst)
        rom_sel |-> prg_addr[13:0] == $past(cpu_addr[13:0]));

    // R13: work RAM only in its window and when enabled
    a_r13_wram_gate: assert property (@(posedge clk) disable iff (rst)
        wram_sel |-> (!$past(wram_dis) && $past(cpu_addr[15:13]) == 3'b011));

    // R13: ROM and work RAM never selected together
    a_r13_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rom_sel, wram_sel}));

    generate
        if (CHR_IS_RAM) begin : g_a_ram
            // R9: writes only for a requested pattern-space write
            a_r9_we_source: assert property (@(posedge clk) disable iff (rst)
                chr_we |-> ($past(ppu_wr) && chr_sel));
        end else begin : g_a_rom
            // R9: ROM boards never write
            a_r9_rom_no_we: assert property (@(posedge clk) disable iff (rst) !chr_we);
            // R8: 4 KB offset passes through
            a_r8_chr_offset: assert property (@(posedge clk) disable iff (rst)
                chr_sel |-> chr_addr[11:0] == $past(ppu_addr[11:0]));
        end
    endgenerate
endmodule

// File: tb/bank_xlat_tb_top.sv
module bank_xlat_tb_top;
    import bank_xlat_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst;
    logic [15:0] cpu_addr;
    logic [13:0] ppu_addr;
    logic        ppu_wr, prg_mode, prg_slot, chr_mode, wram_dis;
    logic [3:0]  prg_bank;
    logic [4:0]  chr_bank0, chr_bank1;

    int n_checks = 0;
    int n_errors = 0;

    // instance 0: plain, PRG 256, CHR ROM 128, WRAM 8
    logic [17:0] p0; logic [16:0] c0; logic [12:0] w0;
    logic rs0, ws0, cs0, we0;
    // instance 1: big program, PRG 512, CHR RAM 8, WRAM 8
    logic [18:0] p1; logic [12:0] c1; logic [12:0] w1;
    logic rs1, ws1, cs1, we1;
    // instance 2: two pages, PRG 128, CHR RAM 8, WRAM 16
    logic [16:0] p2; logic [12:0] c2; logic [13:0] w2;
    logic rs2, ws2, cs2, we2;
    // instance 3: four pages, PRG 256, CHR ROM 64, WRAM 32
    logic [17:0] p3; logic [15:0] c3; logic [14:0] w3;
    logic rs3, ws3, cs3, we3;

    bank_xlat #(.VARIANT(VAR_PLAIN), .PRG_KB(256), .CHR_KB(128), .VRAM_KB(8), .WRAM_KB(8)) dut_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
        .prg_mode(prg_mode), .prg_slot(prg_slot), .chr_mode(chr_mode), .prg_bank(prg_bank),
        .chr_bank0(chr_bank0), .chr_bank1(chr_bank1), .wram_dis(wram_dis),
        .prg_addr(p0), .rom_sel(rs0), .wram_addr(w0), .wram_sel(ws0),
        .chr_addr(c0), .chr_sel(cs0), .chr_we(we0));

    bank_xlat #(.VARIANT(VAR_BIGPRG), .PRG_KB(512), .CHR_KB(0), .VRAM_KB(8), .WRAM_KB(8)) dut_big (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
        .prg_mode(prg_mode), .prg_slot(prg_slot), .chr_mode(chr_mode), .prg_bank(prg_bank),
        .chr_bank0(chr_bank0), .chr_bank1(chr_bank1), .wram_dis(wram_dis),
        .prg_addr(p1), .rom_sel(rs1), .wram_addr(w1), .wram_sel(ws1),
        .chr_addr(c1), .chr_sel(cs1), .chr_we(we1));

    bank_xlat #(.VARIANT(VAR_RAM2), .PRG_KB(128), .CHR_KB(0), .VRAM_KB(8), .WRAM_KB(16)) dut_r2 (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
        .prg_mode(prg_mode), .prg_slot(prg_slot), .chr_mode(chr_mode), .prg_bank(prg_bank),
        .chr_bank0(chr_bank0), .chr_bank1(chr_bank1), .wram_dis(wram_dis),
        .prg_addr(p2), .rom_sel(rs2), .wram_addr(w2), .wram_sel(ws2),
        .chr_addr(c2), .chr_sel(cs2), .chr_we(we2));

    bank_xlat #(.VARIANT(VAR_RAM4), .PRG_KB(256), .CHR_KB(64), .VRAM_KB(8), .WRAM_KB(32)) dut_r4 (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .ppu_addr(ppu_addr), .ppu_wr(ppu_wr),
        .prg_mode(prg_mode), .prg_slot(prg_slot), .chr_mode(chr_mode), .prg_bank(prg_bank),
        .chr_bank0(chr_bank0), .chr_bank1(chr_bank1), .wram_dis(wram_dis),
        .prg_addr(p3), .rom_sel(rs3), .wram_addr(w3), .wram_sel(ws3),
        .chr_addr(c3), .chr_sel(cs3), .chr_we(we3));

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_prg(input int variant, input int prgkb);
        int b;
        int a14 = int'(cpu_addr[14]);
        if (!prg_mode)     b = a14 ? int'(prg_bank) + 1 : int'(prg_bank);
        else if (!prg_slot) b = a14 ? int'(prg_bank) : 0;
        else               b = a14 ? 15 : int'(prg_bank);
        if (variant == 1) b = b | (int'(chr_bank0[4]) << 4);
        b = b & (prgkb / 16 - 1);
        return b * 16384 + int'(cpu_addr[13:0]);
    endfunction

    function automatic int exp_chr(input int chrkb, input int vramkb);
        int b;
        if (chrkb == 0) return int'(ppu_addr[12:0]) & (vramkb * 1024 - 1);
        if (!chr_mode) b = ppu_addr[12] ? int'(chr_bank0) + 1 : int'(chr_bank0);
        else           b = ppu_addr[12] ? int'(chr_bank1) : int'(chr_bank0);
        b = b & (chrkb / 4 - 1);
        return b * 4096 + int'(ppu_addr[11:0]);
    endfunction

    function automatic int exp_wram(input int variant, input int wramkb);
        int pg = 0;
        if (variant == 2) pg = int'(chr_bank0[3]);
        if (variant == 3) pg = int'(chr_bank0[3:2]);
        return (pg * 8192 + int'(cpu_addr[12:0])) & (wramkb * 1024 - 1);
    endfunction

    function automatic string prg_tag();
        if (!prg_mode) return "R2";
        if (!prg_slot) return "R3";
        return "R4";
    endfunction

    // drive at negedge, capture at posedge, sample 1 ns later
    task automatic step_and_check();
        int esel_w, esel_c;
        string pt, ct;
        @(posedge clk);
        #1;
        pt = prg_tag();
        ct = chr_mode ? "R7" : "R6";
        esel_w = (cpu_addr[15:13] == 3'b011 && !wram_dis) ? 1 : 0;
        esel_c = ppu_addr[13] ? 0 : 1;
        chk(pt,    "plain prg_addr (R5)", int'(p0), exp_prg(0, 256));
        chk("R10", "big prg_addr",        int'(p1), exp_prg(1, 512));
        chk(pt,    "ram2 prg_addr (R5)",  int'(p2), exp_prg(2, 128));
        chk(pt,    "ram4 prg_addr (R5)",  int'(p3), exp_prg(3, 256));
        chk("R5",  "rom_sel",             int'(rs0), int'(cpu_addr[15]));
        chk("R5",  "rom_sel big",         int'(rs1), int'(cpu_addr[15]));
        chk(ct,    "plain chr_addr (R8)", int'(c0), exp_chr(128, 8));
        chk(ct,    "ram4 chr_addr (R8)",  int'(c3), exp_chr(64, 8));
        chk("R9",  "big chr_addr",        int'(c1), exp_chr(0, 8));
        chk("R9",  "ram2 chr_addr",       int'(c2), exp_chr(0, 8));
        chk("R8",  "chr_sel",             int'(cs0), esel_c);
        chk("R8",  "chr_sel ram2",        int'(cs2), esel_c);
        chk("R9",  "chr_we rom",          int'(we0), 0);
        chk("R9",  "chr_we rom ram4",     int'(we3), 0);
        chk("R9",  "chr_we ram",          int'(we1), (ppu_wr && !ppu_addr[13]) ? 1 : 0);
        chk("R13", "plain wram_addr",     int'(w0), exp_wram(0, 8));
        chk("R13", "big wram_addr",       int'(w1), exp_wram(1, 8));
        chk("R11", "ram2 wram_addr",      int'(w2), exp_wram(2, 16));
        chk("R12", "ram4 wram_addr",      int'(w3), exp_wram(3, 32));
        chk("R13", "wram_sel",            int'(ws0), esel_w);
        chk("R13", "wram_sel ram4",       int'(ws3), esel_w);
    endtask

    task automatic drive(input logic pm, input logic ps, input logic cm, input logic [3:0] pb,
                         input logic [4:0] b0, input logic [4:0] b1, input logic dis,
                         input logic [15:0] ca, input logic [13:0] pa, input logic wr);
        @(negedge clk);
        prg_mode = pm; prg_slot = ps; chr_mode = cm; prg_bank = pb;
        chr_bank0 = b0; chr_bank1 = b1; wram_dis = dis;
        cpu_addr = ca; ppu_addr = pa; ppu_wr = wr;
        step_and_check();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7321));
        rst = 1'b1;
        cpu_addr = 16'hFFFF; ppu_addr = 14'h0ABC; ppu_wr = 1'b1;
        prg_mode = 1'b1; prg_slot = 1'b1; chr_mode = 1'b1; prg_bank = 4'hA;
        chr_bank0 = 5'h1F; chr_bank1 = 5'h11; wram_dis = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "rom_sel in reset",  int'(rs0), 0);
        chk("R1", "prg_addr in reset", int'(p0), 0);
        chk("R1", "chr_sel in reset",  int'(cs1), 0);
        chk("R1", "chr_we in reset",   int'(we1), 0);
        chk("R1", "wram_sel in reset", int'(ws3), 0);
        @(negedge clk);
        rst = 1'b0;

        // R2: bank 15 + 1 wraps past 256 KB mask to bank 0
        drive(1'b0, 1'b0, 1'b0, 4'hF, 5'h00, 5'h00, 1'b0, 16'hC123, 14'h0010, 1'b0);
        // R2: lower half of 32 KB pair
        drive(1'b0, 1'b1, 1'b0, 4'h6, 5'h00, 5'h00, 1'b0, 16'h8456, 14'h0010, 1'b0);
        // R3: lower window pinned to bank 0
        drive(1'b1, 1'b0, 1'b0, 4'h9, 5'h00, 5'h00, 1'b0, 16'h8001, 14'h0010, 1'b0);
        // R4: upper window pinned to 15; R10 adds bit 4 -> bank 31 on big board
        drive(1'b1, 1'b1, 1'b1, 4'h3, 5'h10, 5'h02, 1'b0, 16'hFFFF, 14'h1FFF, 1'b0);
        // R6: chr bank 31 + 1 past the mask
        drive(1'b1, 1'b0, 1'b0, 4'h2, 5'h1F, 5'h05, 1'b0, 16'h6ABC, 14'h1234, 1'b1);
        // R13: work RAM disabled over its window
        drive(1'b1, 1'b0, 1'b1, 4'h2, 5'h0C, 5'h05, 1'b1, 16'h7FFF, 14'h2345, 1'b1);
        // R12 / R11: page bits set, RAM enabled
        drive(1'b1, 1'b0, 1'b1, 4'h2, 5'h0C, 5'h05, 1'b0, 16'h7FFF, 14'h0345, 1'b1);
        // R9: write above pattern space is refused
        drive(1'b0, 1'b0, 1'b1, 4'h1, 5'h04, 5'h08, 1'b0, 16'h5000, 14'h3000, 1'b1);

        for (int i = 0; i < 800; i++) begin
            drive(1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom),
                  5'($urandom), 5'($urandom), 1'(($urandom % 4) == 0),
                  16'($urandom), 14'($urandom), 1'($urandom));
        end
        finish_run();
    end
endmodule